// File: doc/BRIEF.md
# Taylor-series quadrature NCO

This block is the oscillator of a carrier-recovery loop. Each accepted sample strobe moves a 32-bit phase register forward by a fixed centre step. A scaled copy of the loop's signed error word is added to that step. The new phase is folded back into the interval from minus pi to plus pi. The block then returns a cosine and a sine of the phase as signed Q15 words, with a one-cycle valid pulse.

The block uses no table and no rotation engine. The folded phase is divided by four, which keeps the polynomial argument below pi/4 radians. Short Horner-form Taylor polynomials give the cosine and sine of that quarter angle. Two double-angle steps then give the cosine of the full angle, and the sine of the full angle is built as four times sine, times cosine, times the second cosine of the double-angle chain. A single shared Q15 multiplier is stepped through these products, so one result takes a fixed run of cycles. Strobes that arrive during that run are dropped.

Top module: `nco_quad`

## Requirements
- R1: While reset is held, `cos_o` and `sin_o` are 0 and `valid_o` is low. Reset clears the phase register, so the first result after reset is for the phase 0 + centre step + error term.
- R2: Each accepted strobe produces exactly one `valid_o` pulse, one cycle long. The outputs keep their values between pulses.
- R3: With a zero error word, each accepted strobe adds the centre step 0x4F35 (20277, which is 0.6188 rad, because the phase counts radians times 32768) to the phase register.
- R4: The error word is shifted right arithmetically by 6, multiplied by the loop gain 2, and added together with the centre step. For example, -1 adds -2 and 0x7FFF adds +1022.
- R5: After each update the magnitude of the sum is reduced by 2*pi (205887) while it exceeds pi (102944). The sign is then restored, so the phase always lies in [-102944, +102944].
- R6: The phase is shifted right arithmetically by 2 to form the polynomial argument, which stays within ±25736 (pi/4). The outputs equal cos and sin of 4·(phase>>>2)/32768 rad, scaled by 32767, within 64 LSB.
- R7: The outputs are signed Q15 and saturate, so +1.0 reads 0x7FFF. At a quarter-angle argument of 0, `cos_o` is exactly 0x7FFF and `sin_o` is exactly 0x0000.
- R8: A strobe that arrives while a result is being computed is ignored and does not touch the phase. A strobe in the same cycle as a `valid_o` pulse is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| strobe_i | input | 1 | Sample strobe; starts one phase update and one evaluation |
| err_i | input | 16 | Signed loop-error word, sampled with an accepted strobe |
| cos_o | output | 16 | Cosine of the phase, signed Q15 |
| sin_o | output | 16 | Sine of the phase, signed Q15 |
| valid_o | output | 1 | One-cycle pulse when new outputs are presented |

## Verification
Two events can fall in the same cycle: the `valid_o` pulse that closes one evaluation and a fresh strobe that opens the next. The bench watches for the pulse and raises the strobe in that same cycle. It then expects two results in a row, and the second must follow the phase model with both updates applied. A second case puts a strobe with a large error word in the middle of a busy evaluation. The next ordinary result must show that this strobe left the phase untouched.

// File: rtl/nco_pkg.sv
package nco_pkg;
    // Q15 datapath: FRAC fractional bits, with headroom for the value 1.0 and a sign bit
    localparam int FRAC  = 15;
    localparam int OUT_W = 16;
    localparam int IW    = FRAC + 3;
    localparam int XW    = IW + 2;

    typedef logic signed [IW-1:0]    qint_t;
    typedef logic signed [OUT_W-1:0] qout_t;

    localparam qint_t Q_ONE   = qint_t'(2**FRAC);
    // Horner coefficients of the cosine polynomial, as Q15 values
    localparam qint_t K_C2    = qint_t'(16384);   // 1/2
    localparam qint_t K_C4    = qint_t'(1365);    // 1/24
    localparam qint_t K_C6    = qint_t'(46);      // 1/720
    // Horner coefficients of the sine polynomial, as Q15 values
    localparam qint_t K_S3    = qint_t'(5461);    // 1/6
    localparam qint_t K_S5    = qint_t'(273);     // 1/120
    localparam qint_t K_S7    = qint_t'(7);       // 1/5040
    // Largest quarter-angle argument, pi/4 in Q15
    localparam qint_t QTR_PI  = qint_t'(25736);

    // Phase constants, radians times 2^FRAC
    localparam logic signed [31:0] PHASE_PI  = 32'sd102944;
    localparam logic signed [31:0] PHASE_2PI = 32'sd205887;

    function automatic qout_t q_sat(input logic signed [XW-1:0] v);
        logic signed [XW-1:0] hi;
        logic signed [XW-1:0] lo;
        hi = XW'((2**(OUT_W-1)) - 1);
        lo = -XW'(2**(OUT_W-1));
        if (v > hi)      return qout_t'(hi);
        else if (v < lo) return qout_t'(lo);
        else             return qout_t'(v);
    endfunction
endpackage

// File: rtl/nco_qmul.sv
module nco_qmul #(
    parameter int W     = 18,
    parameter int FBITS = 15,
    parameter int ROUND = 1
) (
    input  logic signed [W-1:0] a_i,
    input  logic signed [W-1:0] b_i,
    output logic signed [W-1:0] p_o
);
    localparam int PW = 2 * W;

    logic signed [PW-1:0] full;
    logic signed [PW-1:0] biased;

    assign full = PW'(a_i) * PW'(b_i);

    generate
        if (ROUND != 0) begin : g_round
            assign biased = full + (PW'(1) <<< (FBITS - 1));
        end else begin : g_trunc
            assign biased = full;
        end
    endgenerate

    assign p_o = W'(biased >>> FBITS);
endmodule

// File: rtl/nco_phase_acc.sv
module nco_phase_acc
    import nco_pkg::*;
#(
    parameter int          ACC_W      = 32,
    parameter int          ERR_W      = 16,
    parameter int          ERR_SHIFT  = 6,
    parameter int          VCO_GAIN   = 2,
    parameter logic [31:0] CENTER_INC = 32'h0000_4F35
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start_i,
    input  logic signed [ERR_W-1:0] err_i,
    output logic                    done_o,
    output logic signed [ACC_W-1:0] phase_o
);
    typedef logic signed [ACC_W-1:0] acc_t;

    localparam acc_t PI_A     = acc_t'(PHASE_PI);
    localparam acc_t TWO_PI_A = acc_t'(PHASE_2PI);
    localparam acc_t STEP_A   = acc_t'(CENTER_INC);
    localparam acc_t GAIN_A   = acc_t'(VCO_GAIN);

    typedef enum logic {PA_IDLE, PA_FOLD} pa_st_e;

    typedef struct packed {
        pa_st_e st;
        logic   neg;
        acc_t   mag;
        acc_t   acc;
        logic   done;
    } pa_reg_t;

    pa_reg_t r_d, r_q;
    acc_t    err_term;
    acc_t    sum;

    always_comb begin
        err_term = acc_t'(err_i >>> ERR_SHIFT) * GAIN_A;
        sum      = r_q.acc + STEP_A + err_term;
        r_d      = r_q;
        r_d.done = 1'b0;
        case (r_q.st)
            PA_IDLE: begin
                if (start_i) begin
                    r_d.neg = sum[ACC_W-1];
                    r_d.mag = sum[ACC_W-1] ? -sum : sum;
                    r_d.st  = PA_FOLD;
                end
            end
            PA_FOLD: begin
                if (r_q.mag > PI_A) begin
                    r_d.mag = r_q.mag - TWO_PI_A;
                end else begin
                    r_d.acc  = r_q.neg ? -r_q.mag : r_q.mag;
                    r_d.done = 1'b1;
                    r_d.st   = PA_IDLE;
                end
            end
            default: r_d.st = PA_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign done_o  = r_q.done;
    assign phase_o = r_q.acc;

    // R5
    fold_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.done |-> (r_q.acc <= PI_A && r_q.acc >= -PI_A));

    // R3
    acc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !r_q.done |-> $stable(r_q.acc));

    // R8
    start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |-> (r_q.st == PA_IDLE));
endmodule

// File: rtl/nco_trig_core.sv
module nco_trig_core
    import nco_pkg::*;
#(
    parameter int ROUND = 1
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  start_i,
    input  qout_t x_i,
    output logic  done_o,
    output qout_t cos_o,
    output qout_t sin_o
);
    localparam int STEP_W = 4;

    typedef struct packed {
        logic              busy;
        logic [STEP_W-1:0] step;
        qint_t             x;
        qint_t             u;
        qint_t             a;
        qint_t             b;
        qint_t             c;
        logic              done;
        qout_t             cos_v;
        qout_t             sin_v;
    } tc_reg_t;

    tc_reg_t r_d, r_q;
    qint_t   mul_a, mul_b, prod, dbl;
    logic signed [XW-1:0] prod4;

    nco_qmul #(.W(IW), .FBITS(FRAC), .ROUND(ROUND)) u_mul (
        .a_i(mul_a),
        .b_i(mul_b),
        .p_o(prod)
    );

    assign dbl   = (prod <<< 1) - Q_ONE;
    assign prod4 = $signed({prod, 2'b00});

    // Operand selection per step of the schedule
    always_comb begin
        case (r_q.step)
            4'd0:    begin mul_a = r_q.x; mul_b = r_q.x; end
            4'd1:    begin mul_a = r_q.u; mul_b = K_C6;  end
            4'd2:    begin mul_a = r_q.u; mul_b = r_q.a; end
            4'd3:    begin mul_a = r_q.u; mul_b = r_q.a; end
            4'd4:    begin mul_a = r_q.u; mul_b = K_S7;  end
            4'd5:    begin mul_a = r_q.u; mul_b = r_q.b; end
            4'd6:    begin mul_a = r_q.u; mul_b = r_q.b; end
            4'd7:    begin mul_a = r_q.x; mul_b = r_q.b; end
            4'd8:    begin mul_a = r_q.c; mul_b = r_q.c; end
            4'd9:    begin mul_a = r_q.b; mul_b = r_q.c; end
            4'd10:   begin mul_a = r_q.a; mul_b = r_q.a; end
            default: begin mul_a = r_q.b; mul_b = r_q.a; end
        endcase
    end

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        if (!r_q.busy) begin
            if (start_i) begin
                r_d.busy = 1'b1;
                r_d.step = '0;
                r_d.x    = {{(IW-OUT_W){x_i[OUT_W-1]}}, x_i};
            end
        end else begin
            r_d.step = r_q.step + 1'b1;
            case (r_q.step)
                4'd0:  r_d.u = prod;               // x^2
                4'd1:  r_d.a = K_C4 - prod;
                4'd2:  r_d.a = K_C2 - prod;
                4'd3:  r_d.c = Q_ONE - prod;       // cos of quarter angle
                4'd4:  r_d.b = K_S5 - prod;
                4'd5:  r_d.b = K_S3 - prod;
                4'd6:  r_d.b = Q_ONE - prod;
                4'd7:  r_d.b = prod;               // sin of quarter angle
                4'd8:  r_d.a = dbl;                // cos of half angle
                4'd9:  r_d.b = prod;               // sin * cos
                4'd10: r_d.c = dbl;                // cos of full angle
                default: begin
                    r_d.busy  = 1'b0;
                    r_d.done  = 1'b1;
                    r_d.cos_v = q_sat(XW'(r_q.c));
                    r_d.sin_v = q_sat(prod4);
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign done_o = r_q.done;
    assign cos_o  = r_q.cos_v;
    assign sin_o  = r_q.sin_v;

    // R6
    x_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |-> ($signed(x_i) <= $signed(QTR_PI) && $signed(x_i) >= -$signed(QTR_PI)));

    // R8
    start_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |-> !r_q.busy);
endmodule

// File: rtl/nco_quad.sv
module nco_quad
    import nco_pkg::*;
#(
    parameter int          ACC_W      = 32,
    parameter int          ERR_W      = 16,
    parameter int          ERR_SHIFT  = 6,
    parameter int          VCO_GAIN   = 2,
    parameter logic [31:0] CENTER_INC = 32'h0000_4F35,
    parameter int          ROUND      = 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    strobe_i,
    input  logic signed [ERR_W-1:0] err_i,
    output logic signed [OUT_W-1:0] cos_o,
    output logic signed [OUT_W-1:0] sin_o,
    output logic                    valid_o
);
    typedef enum logic [1:0] {TOP_IDLE, TOP_PHASE, TOP_TRIG} top_st_e;

    typedef struct packed {
        top_st_e st;
        qout_t   cos_v;
        qout_t   sin_v;
        logic    valid;
    } top_reg_t;

    top_reg_t r_d, r_q;

    logic                    ph_start, ph_done;
    logic signed [ACC_W-1:0] ph_phase;
    logic                    tr_start, tr_done;
    qout_t                   tr_x, tr_cos, tr_sin;

    assign ph_start = (r_q.st == TOP_IDLE) && strobe_i;
    assign tr_start = (r_q.st == TOP_PHASE) && ph_done;
    assign tr_x     = OUT_W'(ph_phase >>> 2);

    nco_phase_acc #(
        .ACC_W(ACC_W), .ERR_W(ERR_W), .ERR_SHIFT(ERR_SHIFT),
        .VCO_GAIN(VCO_GAIN), .CENTER_INC(CENTER_INC)
    ) u_phase (
        .clk(clk), .rst_n(rst_n), .start_i(ph_start), .err_i(err_i),
        .done_o(ph_done), .phase_o(ph_phase)
    );

    nco_trig_core #(.ROUND(ROUND)) u_trig (
        .clk(clk), .rst_n(rst_n), .start_i(tr_start), .x_i(tr_x),
        .done_o(tr_done), .cos_o(tr_cos), .sin_o(tr_sin)
    );

    always_comb begin
        r_d       = r_q;
        r_d.valid = 1'b0;
        case (r_q.st)
            TOP_IDLE:  if (strobe_i) r_d.st = TOP_PHASE;
            TOP_PHASE: if (ph_done)  r_d.st = TOP_TRIG;
            TOP_TRIG: begin
                if (tr_done) begin
                    r_d.cos_v = tr_cos;
                    r_d.sin_v = tr_sin;
                    r_d.valid = 1'b1;
                    r_d.st    = TOP_IDLE;
                end
            end
            default: r_d.st = TOP_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign cos_o   = r_q.cos_v;
    assign sin_o   = r_q.sin_v;
    assign valid_o = r_q.valid;

    // R2
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

    // R2
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> ($stable(cos_o) && $stable(sin_o)));

    // R5
    phase_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tr_start |-> (ph_phase <= ACC_W'(PHASE_PI) && ph_phase >= -ACC_W'(PHASE_PI)));
endmodule

// File: tb/nco_quad_tb.sv
`timescale 1ns/1ps
module nco_quad_tb;
    localparam int     TOL    = 64;
    localparam longint STEP   = 20277;
    localparam longint PI_Q   = 102944;
    localparam longint TWOPI_Q = 205887;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               strobe = 1'b0;
    logic signed [15:0] err = '0;
    logic signed [15:0] cos_w, sin_w;
    logic               valid_w;

    nco_quad u_dut (
        .clk(clk), .rst_n(rst_n), .strobe_i(strobe), .err_i(err),
        .cos_o(cos_w), .sin_o(sin_w), .valid_o(valid_w)
    );

    always #4 clk = ~clk;

    typedef struct {
        int    c;
        int    s;
        int    tol;
        string req;
    } exp_t;

    exp_t   sb[$];
    int     checks = 0, errors = 0, pulses = 0, accepted = 0;
    longint m_acc = 0;
    bit     prev_v = 1'b0;

    task automatic check_eq(input string req, input string what, input int act, input int exp, input int tol);
        checks++;
        if (act - exp > tol || exp - act > tol) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d (tol %0d)", req, what, act, exp, tol);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Phase model taken from R3, R4, R5; returns 1 when a fold happened
    function automatic bit model_step(input logic signed [15:0] e);
        longint s, mag;
        bit neg, folded;
        folded = 1'b0;
        s = m_acc + STEP + longint'(e >>> 6) * 2;
        neg = (s < 0);
        mag = neg ? -s : s;
        while (mag > PI_Q) begin
            mag = mag - TWOPI_Q;
            folded = 1'b1;
        end
        m_acc = neg ? -mag : mag;
        return folded;
    endfunction

    function automatic int q15(input real v);
        real t;
        t = v * 32767.0;
        return (t >= 0.0) ? $rtoi(t + 0.5) : -$rtoi(-t + 0.5);
    endfunction

    task automatic push_exp(input string req, input int tol);
        exp_t   e;
        longint xq;
        real    ang;
        xq = m_acc >>> 2;
        ang = real'(xq) * 4.0 / 32768.0;
        e.c = q15($cos(ang));
        e.s = q15($sin(ang));
        e.tol = tol;
        e.req = req;
        sb.push_back(e);
        accepted++;
    endtask

    task automatic send(input logic signed [15:0] e, input string req, input int tol);
        bit f;
        @(negedge clk);
        err = e;
        strobe = 1'b1;
        f = model_step(e);
        push_exp((f && req == "R3") ? "R5" : req, tol);
        @(negedge clk);
        strobe = 1'b0;
    endtask

    task automatic wait_idle();
        int cnt;
        cnt = 0;
        while (sb.size() != 0 && cnt < 200) begin
            @(negedge clk);
            cnt++;
        end
        if (sb.size() != 0) begin
            check_eq("R2", "result timeout, pending", sb.size(), 0, 0);
            sb.delete();
        end
        repeat (2) @(negedge clk);
    endtask

    // Monitor: scoreboard compare on every valid pulse
    always @(negedge clk) begin
        exp_t e;
        if (rst_n) begin
            if (valid_w) begin
                pulses++;
                if (prev_v) check_eq("R2", "valid wider than one cycle", 1, 0, 0);
                if (sb.size() == 0) begin
                    check_eq("R8", "unexpected result pulse", 1, 0, 0);
                end else begin
                    e = sb.pop_front();
                    check_eq(e.req, "cos", int'(cos_w), e.c, e.tol);
                    check_eq(e.req, "sin", int'(sin_w), e.s, e.tol);
                end
            end
            prev_v = valid_w;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R2 watchdog: actual still running expected finished");
        finish_run();
    end

    initial begin
        bit hit;
        repeat (3) @(negedge clk);
        // R1 reset state
        check_eq("R1", "cos in reset", int'(cos_w), 0, 0);
        check_eq("R1", "sin in reset", int'(sin_w), 0, 0);
        check_eq("R1", "valid in reset", int'(valid_w), 0, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1 first result starts from a cleared phase
        send(16'sd0, "R1", TOL); wait_idle();

        // R3 free running, folds tagged R5
        for (int i = 0; i < 14; i++) begin
            send(16'sd0, "R3", TOL); wait_idle();
        end

        // R4 error scaling
        send(16'sh7FFF, "R4", TOL); wait_idle();
        send(-16'sd32768, "R4", TOL); wait_idle();
        send(16'sh1234, "R4", TOL); wait_idle();
        send(-16'sd1000, "R4", TOL); wait_idle();
        send(-16'sd1, "R4", TOL); wait_idle();

        // R6 mixed error pattern
        for (int i = 0; i < 10; i++) begin
            send(16'(i * 3001 - 15000), "R6", TOL); wait_idle();
        end

        // R7 steer the phase to zero, expect exact full-scale cosine
        hit = 1'b0;
        for (int i = 0; i < 400 && !hit; i++) begin
            longint s0;
            longint k;
            s0 = m_acc + STEP;
            if (s0 >= -1020 && s0 <= 1020) begin
                k = ((s0 % 2) == 0) ? (-s0 / 2) : ((-s0 + 1) / 2);
                send(16'(k * 64), "R7", 0); wait_idle();
                hit = 1'b1;
            end else begin
                send(16'sd0, "R3", TOL); wait_idle();
            end
        end
        check_eq("R7", "zero phase reached", int'(hit), 1, 0);

        // R8 strobe during a busy evaluation is dropped
        send(16'sd300, "R8", TOL);
        repeat (2) @(negedge clk);
        err = 16'sh4000;
        strobe = 1'b1;
        @(negedge clk);
        strobe = 1'b0;
        wait_idle();
        send(16'sd0, "R8", TOL); wait_idle();

        // R8 strobe in the same cycle as the valid pulse is taken
        send(16'sd0, "R8", TOL);
        do @(negedge clk); while (!valid_w);
        err = -16'sd5000;
        strobe = 1'b1;
        void'(model_step(-16'sd5000));
        push_exp("R8", TOL);
        @(negedge clk);
        strobe = 1'b0;
        wait_idle();

        // R2 one pulse per accepted strobe
        check_eq("R2", "pulse count", pulses, accepted, 0);
        finish_run();
    end
endmodule